// File: doc/BRIEF.md
# Delayed-Branch Instruction Fetch Controller

This block is the front end of a four-stage in-order pipeline. The stages are fetch, decode, operand read and execute. It drives the program counter toward an instruction memory. Each cycle it takes the returned word into the fetch slot and moves the three older stage registers forward, so one instruction is issued per cycle. The instruction word arrives with a ready flag, an externally decoded branch kind and an absolute word-address target, all for the address on the program counter.

Two branch kinds are resolved, and both resolve when the branch reaches execute.

- A standard branch flushes every younger instruction and refetches from the target. The branch costs four cycles in total.
- A delayed branch keeps the three instructions fetched after it. The program counter moves to the target in the same cycle that the third of those instructions is fetched, so the branch costs a single cycle.

A branch that turns up inside a delayed branch's three-slot shadow is ignored and flagged as an error. A stall input freezes the whole front end without losing track of how many shadow slots are still open.

Top module: `dbf_fetch_ctrl`

## Requirements
- R1: On synchronous reset (`rst` high at a clock edge), the program counter loads `RESET_VEC`. Decode, operand-read and execute valid bits (`stage_valid_o[3:1]`) clear, and no branch is left pending.
- R2: With `stall_i` low, `instr_valid_i` high and no redirect, the program counter advances by exactly one word per cycle. An instruction fetched in cycle t is valid in execute in cycle t+3.
- R3: A standard branch (`br_kind_i` = 2'b01) raises `flush_o` in the cycle it sits in execute. All younger instructions lose their valid bits and never reach execute. The target is fetched in the next cycle and reaches execute four cycles after the branch.
- R4: A delayed branch (`br_kind_i` = 2'b10) does not flush. The three sequentially fetched instructions after it execute. The target is fetched in the cycle right after the third of them, so it reaches execute directly behind the third shadow instruction, and the fourth sequential instruction never executes.
- R5: A branch of either kind fetched while a delayed branch still has open shadow slots is ignored, and `err_o` is high in that fetch cycle.
- R6: Branches fetched in the slots that a pending standard branch will flush are ignored without raising `err_o`.
- R7: While `stall_i` is high, the program counter, all stage registers and the pending branch count hold. A redirect due in a stalled cycle happens on the first unstalled cycle.
- R8: With `instr_valid_i` low, the program counter holds, a bubble enters decode, and no delayed-branch shadow slot is consumed. Encodings 2'b00 and 2'b11 on `br_kind_i` mean "not a branch".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Freeze program counter and all stages |
| instr_valid_i | input | 1 | Instruction word for `pc_o` is present this cycle |
| instr_i | input | IW | Instruction word for `pc_o` |
| br_kind_i | input | 2 | Decoded branch kind: 00 none, 01 standard, 10 delayed, 11 none |
| br_target_i | input | AW | Absolute word-address branch target |
| pc_o | output | AW | Program counter (fetch address) |
| stage_valid_o | output | STAGES | Valid per stage; bit 0 fetch, bit 3 execute |
| ex_pc_o | output | AW | Address of the instruction in execute |
| ex_word_o | output | IW | Word of the instruction in execute |
| flush_o | output | 1 | Standard-branch flush of the younger stages |
| err_o | output | 1 | Illegal branch inside a delayed-branch shadow |

## Verification
Two pairs of events can fall in one cycle.

- **Error and redirect together.** The third delayed-branch shadow slot can hold an illegal branch while the redirect to the target takes place. The bench places a second branch in a shadow slot and checks both that `err_o` is counted and that the execute stream still runs through the three shadow words into the target.
- **Stall and redirect together.** A stall can land exactly on the redirect cycle. The bench raises `stall_i` while the third shadow instruction is in fetch. It checks that the program counter holds for the stalled cycles, and that the redirect and the execute order are unchanged once the stall drops.

// File: rtl/dbf_pkg.sv
`timescale 1ns/1ps
package dbf_pkg;

  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_STD  = 2'b01,
    BR_DLY  = 2'b10,
    BR_RSV  = 2'b11
  } br_kind_e;

  // only the two real kinds count as branches; the spare code is inert
  function automatic logic is_branch(input logic [1:0] kind);
    return (kind == BR_STD) || (kind == BR_DLY);
  endfunction

endpackage

// File: rtl/dbf_pc_gen.sv
`timescale 1ns/1ps
module dbf_pc_gen #(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          fetch_v,
  input  logic          redirect,
  input  logic [AW-1:0] tgt,
  output logic [AW-1:0] pc_o
);

  function automatic logic [AW-1:0] seq_next(input logic [AW-1:0] pc);
    return pc + AW'(1);
  endfunction

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)                 pc_q <= RESET_VEC;
    else if (adv) begin
      if (redirect)          pc_q <= tgt;
      else if (fetch_v)      pc_q <= seq_next(pc_q);
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/dbf_branch_track.sv
`timescale 1ns/1ps
module dbf_branch_track
  import dbf_pkg::*;
#(
  parameter int AW     = 16,
  parameter int STAGES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          fetch_v,
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] tgt_i,
  output logic          redirect_o,
  output logic          flush_o,
  output logic          err_o,
  output logic [AW-1:0] tgt_o
);

  localparam int SHADOW = STAGES - 1;
  localparam int CW     = $clog2(SHADOW + 1);

  br_kind_e      pend_q;
  logic [CW-1:0] left_q;
  logic [AW-1:0] tgt_q;

  logic br_seen, in_std, in_dly, last_slot, accept, std_fire, dly_fire;

  always_comb begin
    br_seen   = fetch_v && is_branch(kind_i);
    in_std    = (pend_q == BR_STD);
    in_dly    = (pend_q == BR_DLY);
    last_slot = (left_q == CW'(1));
    accept    = adv && br_seen && (pend_q == BR_NONE);
    // standard: branch moves one stage per unstalled cycle regardless of fetch
    std_fire  = adv && in_std && last_slot;
    // delayed: only real fetches consume shadow slots
    dly_fire  = adv && in_dly && last_slot && fetch_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= BR_NONE;
      left_q <= '0;
      tgt_q  <= '0;
    end else if (adv) begin
      if (accept) begin
        pend_q <= br_kind_e'(kind_i);
        left_q <= CW'(SHADOW);
        tgt_q  <= tgt_i;
      end else if (in_std || (in_dly && fetch_v)) begin
        left_q <= left_q - CW'(1);
        if (last_slot) pend_q <= BR_NONE;
      end
    end
  end

  assign redirect_o = std_fire || dly_fire;
  assign flush_o    = std_fire;
  assign err_o      = adv && br_seen && in_dly;
  assign tgt_o      = tgt_q;

endmodule

// File: rtl/dbf_stage_pipe.sv
`timescale 1ns/1ps
module dbf_stage_pipe #(
  parameter int AW     = 16,
  parameter int IW     = 32,
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              flush,
  input  logic              in_v,
  input  logic [AW-1:0]     in_pc,
  input  logic [IW-1:0]     in_word,
  output logic [STAGES-1:0] valid_o,
  output logic [AW-1:0]     last_pc_o,
  output logic [IW-1:0]     last_word_o
);

  assign valid_o[0] = in_v;

  for (genvar k = 1; k < STAGES; k++) begin : g_st
    logic          v_q;
    logic [AW-1:0] pc_q;
    logic [IW-1:0] w_q;
    logic          prev_v;
    logic [AW-1:0] prev_pc;
    logic [IW-1:0] prev_w;

    if (k == 1) begin : g_head
      assign prev_v  = in_v;
      assign prev_pc = in_pc;
      assign prev_w  = in_word;
    end else begin : g_body
      assign prev_v  = g_st[k-1].v_q;
      assign prev_pc = g_st[k-1].pc_q;
      assign prev_w  = g_st[k-1].w_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q  <= 1'b0;
        pc_q <= '0;
        w_q  <= '0;
      end else if (adv) begin
        v_q  <= prev_v && !flush;
        pc_q <= prev_pc;
        w_q  <= prev_w;
      end
    end

    assign valid_o[k] = v_q;
  end

  assign last_pc_o   = g_st[STAGES-1].pc_q;
  assign last_word_o = g_st[STAGES-1].w_q;

endmodule

// File: rtl/dbf_fetch_ctrl.sv
`timescale 1ns/1ps
module dbf_fetch_ctrl #(
  parameter int            AW        = 16,
  parameter int            IW        = 32,
  parameter int            STAGES    = 4,
  parameter logic [AW-1:0] RESET_VEC = 16'h0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              instr_valid_i,
  input  logic [IW-1:0]     instr_i,
  input  logic [1:0]        br_kind_i,
  input  logic [AW-1:0]     br_target_i,
  output logic [AW-1:0]     pc_o,
  output logic [STAGES-1:0] stage_valid_o,
  output logic [AW-1:0]     ex_pc_o,
  output logic [IW-1:0]     ex_word_o,
  output logic              flush_o,
  output logic              err_o
);

  // named internal events, visible to the bound checker
  logic          adv;
  logic          redirect;
  logic          flush;
  logic [AW-1:0] redir_tgt;
  logic          fetch_live;

  assign adv        = !stall_i;
  assign fetch_live = instr_valid_i && !flush;

  dbf_branch_track #(.AW(AW), .STAGES(STAGES)) u_track (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .fetch_v    (instr_valid_i),
    .kind_i     (br_kind_i),
    .tgt_i      (br_target_i),
    .redirect_o (redirect),
    .flush_o    (flush),
    .err_o      (err_o),
    .tgt_o      (redir_tgt)
  );

  dbf_pc_gen #(.AW(AW), .RESET_VEC(RESET_VEC)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .fetch_v  (instr_valid_i),
    .redirect (redirect),
    .tgt      (redir_tgt),
    .pc_o     (pc_o)
  );

  dbf_stage_pipe #(.AW(AW), .IW(IW), .STAGES(STAGES)) u_pipe (
    .clk         (clk),
    .rst         (rst),
    .adv         (adv),
    .flush       (flush),
    .in_v        (fetch_live),
    .in_pc       (pc_o),
    .in_word     (instr_i),
    .valid_o     (stage_valid_o),
    .last_pc_o   (ex_pc_o),
    .last_word_o (ex_word_o)
  );

  assign flush_o = flush;

endmodule

// File: rtl/dbf_fetch_ctrl_sva.sv
`timescale 1ns/1ps
module dbf_fetch_ctrl_sva #(
  parameter int            AW        = 16,
  parameter int            STAGES    = 4,
  parameter logic [AW-1:0] RESET_VEC = 16'h0010
) (
  input logic              clk,
  input logic              rst,
  input logic              stall_i,
  input logic              instr_valid_i,
  input logic [AW-1:0]     pc_o,
  input logic [STAGES-1:0] stage_valid_o,
  input logic              flush_o,
  input logic              err_o,
  input logic              redirect,
  input logic [AW-1:0]     redir_tgt
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  p_reset_vec_r1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (pc_o == RESET_VEC && stage_valid_o[STAGES-1:1] == '0));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && !stall_i && instr_valid_i && !redirect) |=> (pc_o == $past(pc_o) + AW'(1)));

  p_flush_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (flush_o && !stall_i) |=> (stage_valid_o[STAGES-1:1] == '0));

  p_redirect_tgt_r4: assert property (@(posedge clk) disable iff (rst)
    (redirect && !stall_i) |=> (pc_o == $past(redir_tgt)));

  p_err_no_flush_r5: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !flush_o);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> ($stable(pc_o) && $stable(stage_valid_o[STAGES-1:1])));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!instr_valid_i && !redirect) |=> $stable(pc_o));

endmodule

bind dbf_fetch_ctrl dbf_fetch_ctrl_sva #(
  .AW(AW), .STAGES(STAGES), .RESET_VEC(RESET_VEC)
) u_sva (
  .clk           (clk),
  .rst           (rst),
  .stall_i       (stall_i),
  .instr_valid_i (instr_valid_i),
  .pc_o          (pc_o),
  .stage_valid_o (stage_valid_o),
  .flush_o       (flush_o),
  .err_o         (err_o),
  .redirect      (redirect),
  .redir_tgt     (redir_tgt)
);

// File: tb/dbf_fetch_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbf_fetch_ctrl_tb_top;

  localparam int          AW = 16;
  localparam int          IW = 32;
  localparam logic [15:0] RV = 16'h0010;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall = 1'b0;
  logic          rdy = 1'b1;
  logic [IW-1:0] word;
  logic [1:0]    kind;
  logic [AW-1:0] tgt;
  logic [AW-1:0] pc;
  logic [3:0]    sv;
  logic [AW-1:0] ex_pc;
  logic [IW-1:0] ex_word;
  logic          flush, err;

  logic [1:0]  pk [256];
  logic [15:0] pt [256];

  always #2.5 clk = ~clk;

  assign word = {16'hC0DE, pc};
  assign kind = pk[pc[7:0]];
  assign tgt  = pt[pc[7:0]];

  dbf_fetch_ctrl #(.AW(AW), .IW(IW), .STAGES(4), .RESET_VEC(RV)) dut_i (
    .clk(clk), .rst(rst), .stall_i(stall), .instr_valid_i(rdy), .instr_i(word),
    .br_kind_i(kind), .br_target_i(tgt), .pc_o(pc), .stage_valid_o(sv),
    .ex_pc_o(ex_pc), .ex_word_o(ex_word), .flush_o(flush), .err_o(err)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int stepno, lg_n, flush_n, err_n;
  logic [15:0] lg_pc [64];
  int          lg_st [64];
  logic [15:0] ex_exp [16];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle: sample at the falling edge, log each new execute entry
  task automatic step();
    @(negedge clk);
    stepno++;
    if (sv[3] && lg_n < 64 && (lg_n == 0 || lg_pc[lg_n-1] != ex_pc)) begin
      lg_pc[lg_n] = ex_pc;
      lg_st[lg_n] = stepno;
      chk("R2 word follows address", int'(ex_word), int'({16'hC0DE, ex_pc}));
      lg_n++;
    end
    flush_n += int'(flush);
    err_n   += int'(err);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stall = 1'b0; rdy = 1'b1;
    for (int i = 0; i < 256; i++) begin pk[i] = 2'b00; pt[i] = 16'h0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    stepno = 0; lg_n = 0; flush_n = 0; err_n = 0;
  endtask

  task automatic cmp_log(input string req, input int n);
    chk({req, " exec count"}, (lg_n >= n) ? n : lg_n, n);
    for (int i = 0; i < n && i < lg_n; i++)
      chk({req, " exec order"}, int'(lg_pc[i]), int'(ex_exp[i]));
  endtask

  task automatic t_reset_r1();
    do_reset();
    chk("R1 pc at reset", int'(pc), int'(RV));
    chk("R1 stage valids", int'(sv[3:1]), 0);
    chk("R1 flush/err low", int'({flush, err}), 0);
  endtask

  task automatic t_seq_r2();
    do_reset();
    repeat (6) step();
    chk("R2 pc step", int'(pc), int'(RV + 16'd6));
    for (int i = 0; i < 4; i++) ex_exp[i] = RV + 16'(i);
    cmp_log("R2", 4);
    chk("R2 fetch-to-exec latency", lg_st[0], 3);
  endtask

  task automatic t_std_r3();
    do_reset();
    pk[8'(RV + 2)] = 2'b01; pt[8'(RV + 2)] = 16'h0040;
    repeat (14) step();
    ex_exp[0] = RV; ex_exp[1] = RV + 1; ex_exp[2] = RV + 2;
    ex_exp[3] = 16'h0040; ex_exp[4] = 16'h0041;
    cmp_log("R3", 5);
    chk("R3 flush pulses", flush_n, 1);
    chk("R3 four-cycle cost", lg_st[3] - lg_st[2], 4);
  endtask

  task automatic t_dly_r4();
    do_reset();
    pk[8'(RV + 1)] = 2'b10; pt[8'(RV + 1)] = 16'h0050;
    repeat (12) step();
    for (int i = 0; i < 5; i++) ex_exp[i] = RV + 16'(i);
    ex_exp[5] = 16'h0050; ex_exp[6] = 16'h0051;
    cmp_log("R4", 7);
    chk("R4 no flush", flush_n, 0);
    chk("R4 target right behind shadow", lg_st[5] - lg_st[4], 1);
  endtask

  task automatic t_shadow_r5();
    do_reset();
    pk[8'(RV)]     = 2'b10; pt[8'(RV)]     = 16'h0060;
    pk[8'(RV + 2)] = 2'b01; pt[8'(RV + 2)] = 16'h0070;
    pk[8'(RV + 3)] = 2'b10; pt[8'(RV + 3)] = 16'h0080;
    repeat (10) step();
    for (int i = 0; i < 4; i++) ex_exp[i] = RV + 16'(i);
    ex_exp[4] = 16'h0060;
    cmp_log("R5", 5);
    chk("R5 error pulses", err_n, 2);
    chk("R5 no flush", flush_n, 0);
  endtask

  task automatic t_std_slot_r6();
    do_reset();
    pk[8'(RV)]     = 2'b01; pt[8'(RV)]     = 16'h0040;
    pk[8'(RV + 1)] = 2'b10; pt[8'(RV + 1)] = 16'h0070;
    pk[8'(RV + 2)] = 2'b01; pt[8'(RV + 2)] = 16'h0090;
    repeat (10) step();
    ex_exp[0] = RV; ex_exp[1] = 16'h0040; ex_exp[2] = 16'h0041;
    cmp_log("R6", 3);
    chk("R6 no error", err_n, 0);
  endtask

  task automatic t_stall_r7();
    do_reset();
    pk[8'(RV + 1)] = 2'b10; pt[8'(RV + 1)] = 16'h0050;
    repeat (4) step();
    chk("R7 pc before stall", int'(pc), int'(RV + 16'd4));
    stall = 1'b1;
    step();
    chk("R7 pc held", int'(pc), int'(RV + 16'd4));
    step();
    chk("R7 pc held", int'(pc), int'(RV + 16'd4));
    stall = 1'b0;
    step();
    chk("R7 redirect after stall", int'(pc), 16'h0050);
    repeat (6) step();
    for (int i = 0; i < 5; i++) ex_exp[i] = RV + 16'(i);
    ex_exp[5] = 16'h0050;
    cmp_log("R7", 6);
  endtask

  task automatic t_gap_r8();
    do_reset();
    pk[8'(RV + 1)] = 2'b10; pt[8'(RV + 1)] = 16'h0050;
    pk[8'(RV + 3)] = 2'b11; pt[8'(RV + 3)] = 16'h00A0;
    repeat (2) step();
    rdy = 1'b0;
    step();
    chk("R8 bubble in fetch", int'(sv[0]), 0);
    step();
    chk("R8 pc held", int'(pc), int'(RV + 16'd2));
    rdy = 1'b1;
    repeat (10) step();
    for (int i = 0; i < 5; i++) ex_exp[i] = RV + 16'(i);
    ex_exp[5] = 16'h0050;
    cmp_log("R8", 6);
    chk("R8 spare code inert", err_n, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_r1();
    t_seq_r2();
    t_std_r3();
    t_dly_r4();
    t_shadow_r5();
    t_std_slot_r6();
    t_stall_r7();
    t_gap_r8();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule